// File: doc/BRIEF.md
# Operand Address Sequencer with Page-Cross Timing

This block works out the effective address of one memory operand for an 8-bit processor with a 16-bit address space. A start pulse hands it the addressing mode, the access kind (read, write or read-modify-write), the current program counter, both index registers, the branch decision and the value to store. The block then walks through the bus accesses the operand needs, one per clock cycle. These accesses are the operand bytes at the program counter, the pointer bytes in page zero, the dummy read that indexing across a page costs, and the data access itself.

When it finishes, the block holds the final address, a page-crossed flag, the count of cycles added beyond the base timing, the advanced program counter and the data byte that was read. It returns to idle after a one-cycle done pulse. Relative branches use the same sequencer: it fetches the signed offset and reports the target and its cost.

Mode codes on `mode`: 0 zero page, 1 zero page + X, 2 zero page + Y, 3 absolute, 4 absolute + X, 5 absolute + Y, 6 indexed-indirect (X), 7 indirect-indexed (Y), 8 relative. Kind codes on `kind`: 0 read, 1 write, 2 read-modify-write.

Top module: `eag_top`

## Requirements
- R1: In absolute modes (codes 3, 4, 5) the low address byte is read at PC and the high byte at PC+1, and `pc_out` ends at PC+2.
- R2: Zero-page modes (codes 0, 1, 2) read one operand byte at PC. For codes 1 and 2 the index is added modulo 256, so the final address always has a high byte of zero. `pc_out` ends at PC+1.
- R3: For an indexed read (codes 4, 5, 7, kind 0), a carry out of the low address byte sets `page_cross`, makes `extra_cyc` 1, and inserts one dummy read at the final address with bit 8 inverted before the data read. Without a carry there is no dummy read and `extra_cyc` is 0.
- R4: For an indexed write or read-modify-write (codes 4, 5, 7, kind 1 or 2), a dummy read always happens at {base high byte, low byte of the sum}. `extra_cyc` stays 0, and `page_cross` still reports the carry.
- R5: Indexed-indirect (code 6) adds X to the operand byte modulo 256. It reads the address low byte at that pointer and the high byte at pointer+1 modulo 256, and no dummy read occurs.
- R6: Indirect-indexed (code 7) reads the base low byte at the operand byte and the high byte at operand+1 modulo 256, adds Y, and follows R3 and R4.
- R7: Relative mode (code 8) reads a signed offset at PC. The target is PC+1 plus the sign-extended offset. If taken, `extra_cyc` is 1, or 2 when the target's high byte differs from that of PC+1, and `pc_out` is the target. If not taken, `extra_cyc` is 0 and `pc_out` is PC+1. No data access follows.
- R8: A read-modify-write reads the data byte and finally writes `wr_val`. In every mode other than codes 0, 1 and 2, a write of the unmodified byte comes between the two.
- R9: Address sums are kept to 16 bits, so an indexed address past 0xFFFF wraps into page zero and counts as a page crossing.
- R10: While reset is held and after it is released, the block is idle. It makes no memory access, `done` is 0, and `ea`, `page_cross` and `extra_cyc` read 0.
- R11: The block makes at most one memory access per cycle. `done` is high for exactly one cycle per operation, and `data_q` then holds the byte read at the final address for kinds 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 4 | Addressing mode code |
| kind | input | 2 | Access kind code |
| pc_in | input | 16 | Program counter at the operand's first byte |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| taken | input | 1 | Branch condition holds (relative mode) |
| wr_val | input | 8 | Value to store, or modified value for read-modify-write |
| mem_addr | output | 16 | Memory address of the current access |
| mem_rd | output | 1 | Read strobe; data returned on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Final effective address or branch target |
| pc_out | output | 16 | Program counter after the operand |
| page_cross | output | 1 | Indexing or taken branch crossed a page |
| extra_cyc | output | 2 | Cycles added beyond base timing |
| data_q | output | 8 | Byte read at the final address |

## Verification
The bench targets an odd base high byte crossing a page, where inverting bit 8 and taking the uncorrected page give different dummy addresses. A design that confused the two would issue its dummy read at the wrong location. It also uses pointers at 0xFF, which a design that did not wrap in page zero would fetch from 0x0100. Indexed stores across a page check that no extra cycle is charged, and a base near 0xFFFF checks the 16-bit wrap. Backward and forward branches across page boundaries, a not-taken branch, and read-modify-write in zero-page and absolute modes show whether the write-back of the unmodified byte is placed correctly or left out.

// File: rtl/eag_pkg.sv
package eag_pkg;
    parameter int EAG_AW = 16;
    parameter int EAG_DW = 8;
    localparam int PG_W  = EAG_AW - EAG_DW;
    localparam logic [EAG_AW-1:0] PAGE_LSB = EAG_AW'(1) << EAG_DW;

    typedef enum logic [3:0] {
        AM_ZP   = 4'd0,
        AM_ZPX  = 4'd1,
        AM_ZPY  = 4'd2,
        AM_ABS  = 4'd3,
        AM_ABSX = 4'd4,
        AM_ABSY = 4'd5,
        AM_INDX = 4'd6,
        AM_INDY = 4'd7,
        AM_REL  = 4'd8
    } addr_mode_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_RMW   = 2'd2
    } acc_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_OPLO, SQ_OPHI, SQ_PTRLO, SQ_PTRHI,
        SQ_DUMMY, SQ_DATA, SQ_WBACK, SQ_FINAL, SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [EAG_AW-1:0] ea;
        logic [EAG_AW-1:0] dummy;
        logic              carry;
    } idx_res_t;

    typedef struct packed {
        logic [EAG_AW-1:0] target;
        logic              crossed;
        logic [1:0]        extra;
    } br_res_t;

    function automatic logic mode_indexed(input addr_mode_e m);
        return (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_INDY);
    endfunction

    function automatic logic mode_zpage(input addr_mode_e m);
        return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
    endfunction

    function automatic logic mode_uses_y(input addr_mode_e m);
        return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_INDY);
    endfunction
endpackage

// File: rtl/eag_index_unit.sv
module eag_index_unit
    import eag_pkg::*;
(
    input  logic [EAG_AW-1:0] base,
    input  logic [EAG_DW-1:0] index,
    input  logic              is_read,
    output idx_res_t          res
);
    logic [EAG_DW:0]   low_sum;
    logic [EAG_AW-1:0] full_sum;

    always_comb begin
        low_sum  = {1'b0, base[EAG_DW-1:0]} + {1'b0, index};
        full_sum = base + EAG_AW'(index);
        res.ea    = full_sum;
        res.carry = low_sum[EAG_DW];
        if (is_read)
            res.dummy = full_sum ^ PAGE_LSB;
        else
            res.dummy = {base[EAG_AW-1:EAG_DW], low_sum[EAG_DW-1:0]};
    end
endmodule

// File: rtl/eag_branch_unit.sv
module eag_branch_unit
    import eag_pkg::*;
(
    input  logic [EAG_AW-1:0] pc_next,
    input  logic [EAG_DW-1:0] disp,
    input  logic              taken,
    output br_res_t           res
);
    always_comb begin
        res.target  = pc_next + {{PG_W{disp[EAG_DW-1]}}, disp};
        res.crossed = res.target[EAG_AW-1:EAG_DW] != pc_next[EAG_AW-1:EAG_DW];
        if (!taken)
            res.extra = 2'd0;
        else if (res.crossed)
            res.extra = 2'd2;
        else
            res.extra = 2'd1;
    end
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [1:0]        kind,
    input  logic [EAG_AW-1:0] pc_in,
    input  logic [EAG_DW-1:0] x_in,
    input  logic [EAG_DW-1:0] y_in,
    input  logic              taken,
    input  logic [EAG_DW-1:0] wr_val,
    output logic [EAG_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [EAG_DW-1:0] mem_wdata,
    input  logic [EAG_DW-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [EAG_AW-1:0] ea,
    output logic [EAG_AW-1:0] pc_out,
    output logic              page_cross,
    output logic [1:0]        extra_cyc,
    output logic [EAG_DW-1:0] data_q
);
    seq_state_e        state_q;
    addr_mode_e        mode_q;
    acc_kind_e         kind_q;
    logic [EAG_DW-1:0] x_q, y_q, wv_q, lo_q, ptr_q;
    logic              taken_q;
    logic [EAG_AW-1:0] pc_q, ea_q, dummy_q;
    logic              cross_q;
    logic [1:0]        extra_q;
    logic [EAG_DW-1:0] data_r;

    logic [EAG_DW-1:0] idx_sel;
    logic [EAG_DW-1:0] zp_sum;
    idx_res_t          ires;
    br_res_t           bres;
    logic              indexed;

    assign idx_sel = mode_uses_y(mode_q) ? y_q : x_q;
    assign indexed = mode_indexed(mode_q);
    assign zp_sum  = mem_rdata + ((mode_q == AM_ZP) ? '0 : idx_sel);

    eag_index_unit idx_u (
        .base    ({mem_rdata, lo_q}),
        .index   (indexed ? idx_sel : '0),
        .is_read (kind_q == AK_READ),
        .res     (ires)
    );

    eag_branch_unit br_u (
        .pc_next (pc_q + EAG_AW'(1)),
        .disp    (mem_rdata),
        .taken   (taken_q),
        .res     (bres)
    );

    // Memory port: one access per state.
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            SQ_OPLO, SQ_OPHI: begin
                mem_addr = pc_q;
                mem_rd   = 1'b1;
            end
            SQ_PTRLO, SQ_PTRHI: begin
                mem_addr = {{PG_W{1'b0}}, ptr_q};
                mem_rd   = 1'b1;
            end
            SQ_DUMMY: begin
                mem_addr = dummy_q;
                mem_rd   = 1'b1;
            end
            SQ_DATA: begin
                mem_addr  = ea_q;
                mem_rd    = (kind_q != AK_WRITE);
                mem_wr    = (kind_q == AK_WRITE);
                mem_wdata = wv_q;
            end
            SQ_WBACK: begin
                mem_addr  = ea_q;
                mem_wr    = 1'b1;
                mem_wdata = data_r;
            end
            SQ_FINAL: begin
                mem_addr  = ea_q;
                mem_wr    = 1'b1;
                mem_wdata = wv_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            mode_q  <= AM_ZP;
            kind_q  <= AK_READ;
            x_q     <= '0;
            y_q     <= '0;
            wv_q    <= '0;
            lo_q    <= '0;
            ptr_q   <= '0;
            taken_q <= 1'b0;
            pc_q    <= '0;
            ea_q    <= '0;
            dummy_q <= '0;
            cross_q <= 1'b0;
            extra_q <= '0;
            data_r  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start) begin
                    mode_q  <= addr_mode_e'(mode);
                    kind_q  <= acc_kind_e'(kind);
                    x_q     <= x_in;
                    y_q     <= y_in;
                    wv_q    <= wr_val;
                    taken_q <= taken;
                    pc_q    <= pc_in;
                    cross_q <= 1'b0;
                    extra_q <= '0;
                    state_q <= SQ_OPLO;
                end
                SQ_OPLO: begin
                    lo_q <= mem_rdata;
                    pc_q <= pc_q + EAG_AW'(1);
                    unique case (mode_q)
                        AM_ZP, AM_ZPX, AM_ZPY: begin
                            ea_q    <= {{PG_W{1'b0}}, zp_sum};
                            state_q <= SQ_DATA;
                        end
                        AM_ABS, AM_ABSX, AM_ABSY:
                            state_q <= SQ_OPHI;
                        AM_INDX: begin
                            ptr_q   <= mem_rdata + x_q;
                            state_q <= SQ_PTRLO;
                        end
                        AM_INDY: begin
                            ptr_q   <= mem_rdata;
                            state_q <= SQ_PTRLO;
                        end
                        AM_REL: begin
                            ea_q    <= bres.target;
                            cross_q <= taken_q && bres.crossed;
                            extra_q <= bres.extra;
                            if (taken_q)
                                pc_q <= bres.target;
                            state_q <= SQ_DONE;
                        end
                        default: state_q <= SQ_DONE;
                    endcase
                end
                SQ_PTRLO: begin
                    lo_q    <= mem_rdata;
                    ptr_q   <= ptr_q + EAG_DW'(1);
                    state_q <= SQ_PTRHI;
                end
                SQ_OPHI, SQ_PTRHI: begin
                    if (state_q == SQ_OPHI)
                        pc_q <= pc_q + EAG_AW'(1);
                    ea_q    <= ires.ea;
                    dummy_q <= ires.dummy;
                    cross_q <= indexed && ires.carry;
                    extra_q <= {1'b0, indexed && ires.carry && (kind_q == AK_READ)};
                    if (indexed && ((kind_q != AK_READ) || ires.carry))
                        state_q <= SQ_DUMMY;
                    else
                        state_q <= SQ_DATA;
                end
                SQ_DUMMY: state_q <= SQ_DATA;
                SQ_DATA: begin
                    if (kind_q != AK_WRITE)
                        data_r <= mem_rdata;
                    if (kind_q != AK_RMW)
                        state_q <= SQ_DONE;
                    else if (mode_zpage(mode_q))
                        state_q <= SQ_FINAL;
                    else
                        state_q <= SQ_WBACK;
                end
                SQ_WBACK: state_q <= SQ_FINAL;
                SQ_FINAL: state_q <= SQ_DONE;
                SQ_DONE:  state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != SQ_IDLE);
    assign done       = (state_q == SQ_DONE);
    assign ea         = ea_q;
    assign pc_out     = pc_q;
    assign page_cross = cross_q;
    assign extra_cyc  = extra_q;
    assign data_q     = data_r;
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [EAG_AW-1:0] ea,
    input logic              page_cross,
    input logic [1:0]        extra_cyc,
    input addr_mode_e        mode_q,
    input acc_kind_e         kind_q
);
    a_r11_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ea));

    a_r4_store_no_penalty: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q != AK_READ && mode_q != AM_REL) |-> (extra_cyc == 2'd0));

    a_r3_read_penalty: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == AK_READ && mode_q != AM_REL) |-> (extra_cyc == {1'b0, page_cross}));

    a_r2_zero_page: assert property (@(posedge clk) disable iff (rst)
        (done && mode_zpage(mode_q)) |-> (ea[EAG_AW-1:EAG_DW] == '0));

    a_r7_branch_cost: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == AM_REL && page_cross) |-> (extra_cyc == 2'd2));

    a_r8_write_follows: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd || mem_wr));
endmodule

bind eag_top eag_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ea         (ea),
    .page_cross (page_cross),
    .extra_cyc  (extra_cyc),
    .mode_q     (mode_q),
    .kind_q     (kind_q)
);

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
    import eag_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  kind = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0, y_in = '0, wr_val = '0;
    logic        taken = 1'b0;
    logic [15:0] mem_addr, ea, pc_out;
    logic        mem_rd, mem_wr, busy, done, page_cross;
    logic [7:0]  mem_wdata, mem_rdata, data_q;
    logic [1:0]  extra_cyc;

    always #4 clk = ~clk;

    // memory model: four override bytes over a computed background
    logic [15:0] ov_a0 = '0, ov_a1 = '0, ov_a2 = '0, ov_a3 = '0;
    logic [7:0]  ov_d0 = '0, ov_d1 = '0, ov_d2 = '0, ov_d3 = '0;
    assign mem_rdata = (mem_addr == ov_a0) ? ov_d0 :
                       (mem_addr == ov_a1) ? ov_d1 :
                       (mem_addr == ov_a2) ? ov_d2 :
                       (mem_addr == ov_a3) ? ov_d3 :
                       (mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5);

    function automatic logic [7:0] mdl(input logic [15:0] a);
        if (a == ov_a0) return ov_d0;
        if (a == ov_a1) return ov_d1;
        if (a == ov_a2) return ov_d2;
        if (a == ov_a3) return ov_d3;
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    eag_top dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .kind(kind),
        .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .taken(taken), .wr_val(wr_val),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea), .pc_out(pc_out),
        .page_cross(page_cross), .extra_cyc(extra_cyc), .data_q(data_q)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual %0d expected below 100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    typedef struct packed {
        logic [3:0]  m;
        logic [1:0]  k;
        logic [15:0] pc;
        logic [7:0]  b0, b1, x, y, p0, p1;
        logic        tk;
        logic [7:0]  wv;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{AM_ZP,   AK_READ,  16'h8000, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R2
        '{AM_ZPX,  AK_READ,  16'h8000, 8'hF0, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R2 wrap
        '{AM_ZPY,  AK_WRITE, 16'h8000, 8'h80, 8'h00, 8'h00, 8'h90, 8'h00, 8'h00, 1'b0, 8'h77}, // R2
        '{AM_ABS,  AK_READ,  16'h8000, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R1
        '{AM_ABSX, AK_READ,  16'h8000, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R3 cross
        '{AM_ABSX, AK_READ,  16'h8000, 8'h10, 8'h12, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R3 none
        '{AM_ABSY, AK_WRITE, 16'h8000, 8'hF0, 8'h12, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 8'h5C}, // R4
        '{AM_ABSX, AK_RMW,   16'h8000, 8'h80, 8'h20, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 8'hC3}, // R4 R8
        '{AM_ABSX, AK_READ,  16'h8000, 8'hF0, 8'h21, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R3 odd page
        '{AM_INDX, AK_READ,  16'h8000, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'h34, 8'h56, 1'b0, 8'h00}, // R5 wrap
        '{AM_INDY, AK_READ,  16'h8000, 8'hFF, 8'h00, 8'h00, 8'h10, 8'hF8, 8'h40, 1'b0, 8'h00}, // R6 cross
        '{AM_INDY, AK_WRITE, 16'h8000, 8'h20, 8'h00, 8'h00, 8'h01, 8'h10, 8'h30, 1'b0, 8'h99}, // R6 R4
        '{AM_REL,  AK_READ,  16'h80F0, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00}, // R7 cross
        '{AM_REL,  AK_READ,  16'h8010, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00}, // R7 same
        '{AM_REL,  AK_READ,  16'h8010, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R7 not taken
        '{AM_REL,  AK_READ,  16'h8002, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00}, // R7 back
        '{AM_ABSY, AK_READ,  16'h8000, 8'hF0, 8'hFF, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00}, // R9
        '{AM_ZPX,  AK_RMW,   16'h8000, 8'h33, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 8'h1E}, // R8 zp
        '{AM_ABS,  AK_RMW,   16'h8000, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h2D}, // R8 abs
        '{AM_INDX, AK_WRITE, 16'h8000, 8'hFE, 8'h00, 8'h03, 8'h00, 8'h00, 8'h60, 1'b0, 8'h4B}  // R5
    };

    logic [15:0] ex_a [16];
    logic        ex_w [16];
    logic [7:0]  ex_d [16];
    int          ex_n;
    logic [15:0] lg_a [16];
    logic        lg_w [16];
    logic [7:0]  lg_d [16];
    int          lg_n;

    task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d);
        if (ex_n < 16) begin
            ex_a[ex_n] = a; ex_w[ex_n] = w; ex_d[ex_n] = d;
        end
        ex_n++;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        logic [15:0] base, e_ea, e_pc, tgt, pcn, sum;
        logic [7:0]  ptr, idx, e_data;
        logic        e_cross, carry, got_done;
        logic [1:0]  e_extra;
        // memory overrides
        ptr = (v.m == AM_INDX) ? v.b0 + v.x : v.b0;
        ov_a0 = v.pc; ov_d0 = v.b0;
        ov_a1 = v.pc + 16'd1; ov_d1 = v.b1;
        if (v.m == AM_INDX || v.m == AM_INDY) begin
            ov_a2 = {8'h00, ptr}; ov_d2 = v.p0;
            ov_a3 = {8'h00, 8'(ptr + 8'd1)}; ov_d3 = v.p1;
        end else begin
            ov_a2 = v.pc; ov_d2 = v.b0;
            ov_a3 = v.pc; ov_d3 = v.b0;
        end
        // expected behaviour
        ex_n = 0; e_cross = 0; e_extra = 0; e_data = 0; e_ea = 0;
        push(v.pc, 0, 0);
        e_pc = v.pc + 16'd1;
        base = 0; idx = 0;
        case (v.m)
            AM_ZP:  e_ea = {8'h00, v.b0};
            AM_ZPX: e_ea = {8'h00, 8'(v.b0 + v.x)};
            AM_ZPY: e_ea = {8'h00, 8'(v.b0 + v.y)};
            AM_ABS, AM_ABSX, AM_ABSY: begin
                push(v.pc + 16'd1, 0, 0);
                e_pc = v.pc + 16'd2;
                base = {v.b1, v.b0};
                idx  = (v.m == AM_ABSX) ? v.x : (v.m == AM_ABSY) ? v.y : 8'h00;
            end
            AM_INDX, AM_INDY: begin
                push({8'h00, ptr}, 0, 0);
                push({8'h00, 8'(ptr + 8'd1)}, 0, 0);
                base = {mdl({8'h00, 8'(ptr + 8'd1)}), mdl({8'h00, ptr})};
                idx  = (v.m == AM_INDY) ? v.y : 8'h00;
            end
            default: ;
        endcase
        if (v.m >= AM_ABS && v.m <= AM_INDY) begin
            sum   = base + {8'h00, idx};
            carry = ({1'b0, base[7:0]} + {1'b0, idx}) > 9'd255;
            e_ea  = sum;
            if (v.m == AM_ABSX || v.m == AM_ABSY || v.m == AM_INDY) begin
                e_cross = carry;
                if (v.k == AK_READ) begin
                    if (carry) begin
                        push(sum ^ 16'h0100, 0, 0);
                        e_extra = 1;
                    end
                end else begin
                    push({base[15:8], sum[7:0]}, 0, 0);
                end
            end
        end
        if (v.m == AM_REL) begin
            pcn = v.pc + 16'd1;
            tgt = pcn + {{8{v.b0[7]}}, v.b0};
            e_ea = tgt;
            e_cross = v.tk && (tgt[15:8] != pcn[15:8]);
            e_extra = v.tk ? (e_cross ? 2'd2 : 2'd1) : 2'd0;
            e_pc = v.tk ? tgt : pcn;
        end else begin
            e_data = mdl(e_ea);
            if (v.k == AK_WRITE)
                push(e_ea, 1, v.wv);
            else begin
                push(e_ea, 0, 0);
                if (v.k == AK_RMW) begin
                    if (!(v.m == AM_ZP || v.m == AM_ZPX || v.m == AM_ZPY))
                        push(e_ea, 1, e_data);
                    push(e_ea, 1, v.wv);
                end
            end
        end
        // drive
        @(negedge clk);
        mode = v.m; kind = v.k; pc_in = v.pc; x_in = v.x; y_in = v.y;
        taken = v.tk; wr_val = v.wv; start = 1'b1;
        lg_n = 0; got_done = 0;
        for (int i = 0; i < 40 && !got_done; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (mem_rd || mem_wr) begin
                if (lg_n < 16) begin
                    lg_a[lg_n] = mem_addr; lg_w[lg_n] = mem_wr; lg_d[lg_n] = mem_wdata;
                end
                lg_n++;
            end
            if (done) got_done = 1;
        end
        chk(req, "done seen", {15'd0, got_done}, 16'd1);
        chk(req, "ea", ea, e_ea);
        chk(req, "pc_out", pc_out, e_pc);
        chk(req, "page_cross", {15'd0, page_cross}, {15'd0, e_cross});
        chk(req, "extra_cyc", {14'd0, extra_cyc}, {14'd0, e_extra});
        if (v.m != AM_REL && v.k != AK_WRITE)
            chk("R11", "data_q", {8'd0, data_q}, {8'd0, e_data});
        chk(req, "access count", 16'(lg_n), 16'(ex_n));
        for (int i = 0; i < ex_n && i < lg_n && i < 16; i++) begin
            chk(req, "access addr", lg_a[i], ex_a[i]);
            chk(req, "access write", {15'd0, lg_w[i]}, {15'd0, ex_w[i]});
            if (ex_w[i])
                chk(req, "write data", {8'd0, lg_d[i]}, {8'd0, ex_d[i]});
        end
        @(negedge clk);
        chk("R11", "done single pulse", {15'd0, done}, 16'd0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "busy in reset", {15'd0, busy}, 16'd0);
        chk("R10", "mem strobes in reset", {14'd0, mem_rd, mem_wr}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "done after reset", {15'd0, done}, 16'd0);
        chk("R10", "ea after reset", ea, 16'd0);
        chk("R10", "flags after reset", {13'd0, page_cross, extra_cyc}, 16'd0);

        for (int n = 0; n < NV; n++) begin
            string tag;
            case (VECS[n].m)
                AM_ZP, AM_ZPX, AM_ZPY: tag = "R2";
                AM_ABS:                tag = "R1";
                AM_INDX:               tag = "R5";
                AM_INDY:               tag = "R6";
                AM_REL:                tag = "R7";
                default:               tag = (VECS[n].k == AK_READ) ? "R3" : "R4";
            endcase
            if (VECS[n].k == AK_RMW) tag = "R8";
            if (n == 16) tag = "R9";
            run_vec(VECS[n], tag);
        end

        // R10 idle with no start: no accesses, ea holds
        begin
            logic [15:0] held;
            int acc;
            held = ea; acc = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) acc++;
            end
            chk("R10", "idle accesses", 16'(acc), 16'd0);
            chk("R10", "idle ea hold", ea, held);
        end

        // R10 reset mid-operation returns to idle
        @(negedge clk);
        mode = AM_INDY; kind = AK_RMW; pc_in = 16'h9000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy after mid reset", {15'd0, busy}, 16'd0);
        chk("R10", "strobes after mid reset", {14'd0, mem_rd, mem_wr}, 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule